// File: doc/BRIEF.md
# Dual-Channel DAC Command Port

This block is the serial front end of a two-channel multiplying DAC. A host master sends 16-bit words while holding chip select low. Each word holds a 4-bit command in its upper bits and a 12-bit payload below it. Each channel has two registers. The input register holds a staged code. The output register drives a parallel code bus toward the converter. A control register sets the serial-output drive, pass-through chaining, the clear target and which clock edge the port samples on.

All serial pins are resynchronised into the system clock domain. A word takes effect only when chip select rises after exactly sixteen sampling edges. A read command stages the selected input register, and that value is shifted out during the next frame. Codes narrower than 12 bits sit in the top of the payload field. The block is parameterised by resolution (8, 10 or 12 bits).

An active-low clear input forces every input and output register to zero or to midscale, as the control register selects.

Top module: `ddac_spi_front`

## Requirements
- R1: A word is applied only when chip select rises after exactly 16 sampling edges. Bits arrive MSB first: command in bits 15:12, payload in bits 11:0. A frame with 15 or 17 edges changes no register.
- R2: Commands 1 (channel 0) and 4 (channel 1) copy the payload into that channel's input register and its output code. The code is payload bits 11 down to 12-RES. The other channel is unchanged.
- R3: Commands 3 (channel 0) and 6 (channel 1) copy the code into the input register only. The output code keeps its value.
- R4: Commands 2 (channel 0) and 5 (channel 1) stage a read-back. On the following frame, SDO presents a 16-bit word MSB first, with bit k shown before sampling edge 15-k. Bits 15:12 are zero, and bits 11:0 hold the input register code shifted left by 12-RES.
- R5: Commands 0, 7 to 12, 14 and 15 change no register, whatever the payload.
- R6: Command 13 writes the control register. Payload bits 11:10 are the SDO mode, bit 9 enables chaining, bit 8 selects the midscale clear target, and bit 7 selects rising-edge sampling.
- R7: With control bit 7 at 0, MOSI is sampled on the falling SCLK edge. At 1, it is sampled on the rising edge.
- R8: The SDO mode sets the drive while chip select is low. Modes 00 and 10 always drive (sdo_en high). Mode 01 drives only zeros (sdo_en is the inverse of the data bit). Mode 11 never drives. With chip select high, sdo_en is low.
- R9: When no read-back is staged and chaining is on, a frame shifts out the 16 bits received in the previous frame. With chaining off, it shifts out zeros.
- R10: While clear is low, both registers of both channels hold the clear value, and loads have no effect. The clear value is midscale (code 1<<(RES-1), read back as 0x800) when control bit 8 is 1, and zero otherwise.
- R11: Reset zeroes both output codes, the input registers and the control register, and drops any staged read-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Active-low clear, resynchronised |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out level |
| sdo_en | output | 1 | Serial data out drive enable |
| dac0_code | output | RES | Channel 0 output code |
| dac1_code | output | RES | Channel 1 output code |

## Verification
The bench builds the block with RES=10 and two synchroniser stages. At this resolution the two low payload bits must be dropped, and read-back must realign the code by two places. These bits are set to ones in every load so that a wrong alignment shows. The midscale code 512 must come back as 0x800. With a 10-bit code, the bench sweeps two dozen spread codes per channel and every no-op command. It also covers all four SDO modes and both sampling edges.

// File: rtl/ddac_pkg.sv
package ddac_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 4;
    localparam int FIELD_BITS = FRAME_BITS - CMD_BITS;
    localparam int NUM_CH     = 2;

    localparam logic [CMD_BITS-1:0] CMD_CTRL = 4'd13;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_LOAD_UPD,
        OP_READ,
        OP_LOAD,
        OP_CTRL
    } op_e;

    typedef enum logic [1:0] {
        SDO_PUSH     = 2'b00,
        SDO_OPEN     = 2'b01,
        SDO_PUSH_ALT = 2'b10,
        SDO_OFF      = 2'b11
    } sdo_mode_e;

    typedef struct packed {
        logic [CMD_BITS-1:0]   cmd;
        logic [FIELD_BITS-1:0] field;
    } frame_t;

    typedef struct packed {
        op_e  op;
        logic ch;
    } dec_t;

    typedef struct packed {
        sdo_mode_e sdo_mode;
        logic      chain;
        logic      clr_mid;
        logic      samp_rise;
    } ctrl_t;

    // Channel commands come in groups of three per channel, starting at 1.
    function automatic dec_t decode_cmd(input logic [CMD_BITS-1:0] cmd);
        dec_t d;
        logic [CMD_BITS-1:0] k;
        d.op = OP_NOP;
        d.ch = 1'b0;
        k    = cmd - 4'd1;
        if (cmd == CMD_CTRL) begin
            d.op = OP_CTRL;
        end else if (cmd >= 4'd1 && cmd <= 4'd6) begin
            d.ch = (k >= 4'd3);
            if (k >= 4'd3) k = k - 4'd3;
            case (k)
                4'd0:    d.op = OP_LOAD_UPD;
                4'd1:    d.op = OP_READ;
                default: d.op = OP_LOAD;
            endcase
        end
        return d;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [FIELD_BITS-1:0] f);
        ctrl_t c;
        c.sdo_mode  = sdo_mode_e'(f[11:10]);
        c.chain     = f[9];
        c.clr_mid   = f[8];
        c.samp_rise = f[7];
        return c;
    endfunction

endpackage

// File: rtl/ddac_sync.sv
module ddac_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/ddac_frame_rx.sv
module ddac_frame_rx
    import ddac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk_s,
    input  logic                  cs_n_s,
    input  logic                  mosi_s,
    input  logic                  samp_rise,
    input  logic                  chain,
    input  sdo_mode_e             sdo_mode,
    input  logic                  rb_valid,
    input  logic [FRAME_BITS-1:0] rb_word,
    output logic                  frame_stb,
    output frame_t                frame_word,
    output logic                  rb_take,
    output logic                  sdo,
    output logic                  sdo_en
);

    localparam int CNT_W = $clog2(FRAME_BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_BITS + 1);

    logic                  sclk_d;
    logic                  cs_d;
    logic [CNT_W-1:0]      cnt;
    logic [FRAME_BITS-1:0] sr;

    logic sclk_up, sclk_dn, samp_edge, cs_fall, cs_rise;

    assign sclk_up   = sclk_s & ~sclk_d;
    assign sclk_dn   = ~sclk_s & sclk_d;
    assign samp_edge = samp_rise ? sclk_up : sclk_dn;
    assign cs_fall   = cs_d & ~cs_n_s;
    assign cs_rise   = ~cs_d & cs_n_s;
    assign rb_take   = cs_fall;

    // One register both receives MOSI and presents SDO from its top bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d    <= 1'b0;
            cs_d      <= 1'b1;
            cnt       <= '0;
            sr        <= '0;
            frame_stb <= 1'b0;
        end else begin
            sclk_d    <= sclk_s;
            cs_d      <= cs_n_s;
            frame_stb <= cs_rise && (cnt == CNT_FULL);
            if (cs_fall) begin
                cnt <= '0;
                if (rb_valid)   sr <= rb_word;
                else if (!chain) sr <= '0;
            end else if (!cs_n_s && samp_edge) begin
                sr <= {sr[FRAME_BITS-2:0], mosi_s};
                if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
            end
        end
    end

    assign frame_word = frame_t'(sr);

    always_comb begin
        sdo    = 1'b0;
        sdo_en = 1'b0;
        if (!cs_n_s) begin
            unique case (sdo_mode)
                SDO_PUSH, SDO_PUSH_ALT: begin sdo = sr[FRAME_BITS-1]; sdo_en = 1'b1; end
                SDO_OPEN:               begin sdo = 1'b0; sdo_en = ~sr[FRAME_BITS-1]; end
                default:                begin sdo = 1'b0; sdo_en = 1'b0; end
            endcase
        end
    end

    AST_RB_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cs_fall && rb_valid) |=> (sr[FRAME_BITS-1 -: CMD_BITS] == '0)); // R4

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_SAT) |=> (cnt == CNT_SAT || cnt == '0)); // R1

endmodule

// File: rtl/ddac_regfile.sv
module ddac_regfile
    import ddac_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr_act,
    input  logic                      frame_stb,
    input  frame_t                    frame_word,
    input  logic                      rb_take,
    output ctrl_t                     ctrl_q,
    output logic [NUM_CH-1:0][RES-1:0] dac_q,
    output logic                      rb_valid,
    output logic [FRAME_BITS-1:0]     rb_word
);

    localparam int SHIFT = FIELD_BITS - RES;
    localparam logic [RES-1:0] MID_CODE = {1'b1, {(RES-1){1'b0}}};

    dec_t                  dec;
    logic [RES-1:0]        new_code;
    logic [RES-1:0]        clr_code;
    logic [RES-1:0]        in_arr [NUM_CH];
    logic                  rb_sel;
    logic [FIELD_BITS-1:0] rb_field;

    assign dec      = decode_cmd(frame_word.cmd);
    assign new_code = frame_word.field[FIELD_BITS-1 -: RES];
    assign clr_code = ctrl_q.clr_mid ? MID_CODE : '0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [RES-1:0] in_r;
        logic [RES-1:0] dac_r;
        logic           hit;

        assign hit = frame_stb && (dec.ch == 1'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                in_r  <= '0;
                dac_r <= '0;
            end else if (clr_act) begin
                in_r  <= clr_code;
                dac_r <= clr_code;
            end else if (hit && dec.op == OP_LOAD_UPD) begin
                in_r  <= new_code;
                dac_r <= new_code;
            end else if (hit && dec.op == OP_LOAD) begin
                in_r  <= new_code;
            end
        end

        assign in_arr[g] = in_r;
        assign dac_q[g]  = dac_r;

        AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
            clr_act |=> (dac_r == $past(clr_code) && in_r == $past(clr_code))); // R10

        AST_LOAD_ONLY_KEEPS_DAC: assert property (@(posedge clk) disable iff (rst)
            (frame_stb && dec.op == OP_LOAD && !clr_act) |=> $stable(dac_r)); // R3
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (frame_stb && dec.op == OP_CTRL) begin
            ctrl_q <= unpack_ctrl(frame_word.field);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_valid <= 1'b0;
            rb_sel   <= 1'b0;
        end else if (frame_stb && dec.op == OP_READ) begin
            rb_valid <= 1'b1;
            rb_sel   <= dec.ch;
        end else if (rb_take) begin
            rb_valid <= 1'b0;
        end
    end

    assign rb_field = FIELD_BITS'(in_arr[rb_sel]) << SHIFT;
    assign rb_word  = {{CMD_BITS{1'b0}}, rb_field};

    AST_STAGE_CONSUMED: assert property (@(posedge clk) disable iff (rst)
        rb_take |=> !rb_valid); // R4

endmodule

// File: rtl/ddac_spi_front.sv
module ddac_spi_front
    import ddac_pkg::*;
#(
    parameter int RES         = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr_n,
    input  logic           sclk,
    input  logic           cs_n,
    input  logic           mosi,
    output logic           sdo,
    output logic           sdo_en,
    output logic [RES-1:0] dac0_code,
    output logic [RES-1:0] dac1_code
);

    logic [3:0]                 pins_s;
    logic                       clr_act;
    logic                       frame_stb;
    frame_t                     frame_word;
    logic                       rb_take;
    logic                       rb_valid;
    logic [FRAME_BITS-1:0]      rb_word;
    ctrl_t                      ctrl_q;
    logic [NUM_CH-1:0][RES-1:0] dac_q;

    ddac_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'b1100)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({clr_n, cs_n, sclk, mosi}),
        .q   (pins_s)
    );

    assign clr_act = ~pins_s[3];

    ddac_frame_rx u_rx (
        .clk        (clk),
        .rst        (rst),
        .sclk_s     (pins_s[1]),
        .cs_n_s     (pins_s[2]),
        .mosi_s     (pins_s[0]),
        .samp_rise  (ctrl_q.samp_rise),
        .chain      (ctrl_q.chain),
        .sdo_mode   (ctrl_q.sdo_mode),
        .rb_valid   (rb_valid),
        .rb_word    (rb_word),
        .frame_stb  (frame_stb),
        .frame_word (frame_word),
        .rb_take    (rb_take),
        .sdo        (sdo),
        .sdo_en     (sdo_en)
    );

    ddac_regfile #(.RES(RES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .clr_act    (clr_act),
        .frame_stb  (frame_stb),
        .frame_word (frame_word),
        .rb_take    (rb_take),
        .ctrl_q     (ctrl_q),
        .dac_q      (dac_q),
        .rb_valid   (rb_valid),
        .rb_word    (rb_word)
    );

    assign dac0_code = dac_q[0];
    assign dac1_code = dac_q[1];

    AST_DAC_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        (!frame_stb && !clr_act) |=> ($stable(dac0_code) && $stable(dac1_code))); // R1

    AST_SDO_OFF: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.sdo_mode == SDO_OFF) |-> !sdo_en); // R8

endmodule

// File: tb/ddac_spi_front_bench.sv
`timescale 1ns/1ps
module ddac_spi_front_bench;

    localparam int RES   = 10;
    localparam int SHIFT = 12 - RES;
    localparam int MID   = 1 << (RES - 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr_n = 1'b1;
    logic sclk = 1'b1;
    logic cs_n = 1'b1;
    logic mosi = 1'b0;
    logic sdo, sdo_en;
    logic [RES-1:0] dac0_code, dac1_code;

    always #2.5 clk = ~clk;

    ddac_spi_front #(.RES(RES), .SYNC_STAGES(2)) u_ddac_spi_front (
        .clk (clk), .rst (rst), .clr_n (clr_n), .sclk (sclk), .cs_n (cs_n),
        .mosi (mosi), .sdo (sdo), .sdo_en (sdo_en),
        .dac0_code (dac0_code), .dac1_code (dac1_code)
    );

    int checks = 0;
    int errors = 0;

    // Bench model of the register state
    int          m_in [2];
    int          m_dac [2];
    logic [1:0]  m_mode;
    logic        m_chain, m_mid, m_rise, m_pend, m_pch, m_clr;
    logic [15:0] m_sr;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin m_in[c] = 0; m_dac[c] = 0; end
        m_mode = 2'b00; m_chain = 0; m_mid = 0; m_rise = 0;
        m_pend = 0; m_pch = 0; m_sr = '0;
    endtask

    function automatic int clr_val();
        return m_mid ? MID : 0;
    endfunction

    task automatic apply_cmd(input logic [15:0] w);
        int cmd, code, ch, k;
        cmd  = int'(w[15:12]);
        code = int'(w[11:0]) >> SHIFT;
        if (cmd >= 1 && cmd <= 6) begin
            ch = (cmd - 1) / 3;
            k  = (cmd - 1) % 3;
            if (k == 1) begin
                m_pend = 1; m_pch = ch[0];
            end else if (!m_clr) begin
                m_in[ch] = code;
                if (k == 0) m_dac[ch] = code;
            end
        end else if (cmd == 13) begin
            m_mode = w[11:10]; m_chain = w[9]; m_mid = w[8]; m_rise = w[7];
        end
        if (m_clr) for (int c = 0; c < 2; c++) begin m_in[c] = clr_val(); m_dac[c] = clr_val(); end
    endtask

    task automatic frame(input logic [15:0] w, input int nbits, input string tag);
        logic [15:0] exp_out, got, got_en, exp_eff, exp_en;
        logic idle, b;
        got = '0; got_en = '0;
        if (m_pend) exp_out = 16'((m_in[m_pch] << SHIFT) & 12'hFFF);
        else if (!m_chain) exp_out = '0;
        else exp_out = m_sr;
        m_sr = exp_out;
        m_pend = 0;
        idle = !m_rise;
        @(negedge clk); sclk = idle;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            b = (i < 16) ? w[15-i] : 1'b0;
            mosi = b;
            repeat (6) @(negedge clk);
            if (i < 16) begin
                got[15-i]    = sdo_en ? sdo : 1'b1;
                got_en[15-i] = sdo_en;
            end
            sclk = ~idle;
            repeat (3) @(negedge clk);
            mosi = ~b;
            repeat (3) @(negedge clk);
            sclk = idle;
            m_sr = {m_sr[14:0], b};
        end
        repeat (6) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        if (nbits == 16) begin
            if (m_mode == 2'b11) begin exp_eff = 16'hFFFF; exp_en = 16'h0000; end
            else if (m_mode == 2'b01) begin exp_eff = exp_out; exp_en = ~exp_out; end
            else begin exp_eff = exp_out; exp_en = 16'hFFFF; end
            chk({tag, " sdo"}, int'(got), int'(exp_eff));
            chk({tag, " sdo_en"}, int'(got_en), int'(exp_en));
            apply_cmd(w);
        end
        chk({tag, " dac0"}, int'(dac0_code), m_dac[0]);
        chk({tag, " dac1"}, int'(dac1_code), m_dac[1]);
    endtask

    function automatic logic [15:0] mk(input int cmd, input int code);
        return {4'(cmd), 12'(code << SHIFT) | 12'(3)};
    endfunction

    function automatic logic [15:0] ctrl_w(input logic [1:0] mode, input logic ch,
                                          input logic mid, input logic rise);
        return {4'd13, mode, ch, mid, rise, 7'b0};
    endfunction

    task automatic readback(input int ch, input string tag);
        frame(mk(2 + 3 * ch, 0), 16, tag);
        frame(16'h0000, 16, tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        model_reset();
        m_clr = 0;
        repeat (6) @(negedge clk);
        // R11: reset state
        chk("R11 reset dac0", int'(dac0_code), 0);
        chk("R11 reset dac1", int'(dac1_code), 0);
        chk("R11 reset sdo_en idle", int'(sdo_en), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        readback(0, "R4 initial readback");

        // R2 load-and-update sweep with read-back (R4)
        for (int ch = 0; ch < 2; ch++) begin
            for (int k = 0; k < 24; k++) begin
                int code;
                code = (k == 23) ? (1 << RES) - 1 : (k * 89 + ch * 7) % (1 << RES);
                frame(mk(1 + 3 * ch, code), 16, "R2 load-update");
                readback(ch, "R4 readback");
            end
        end

        // R3 load only
        for (int ch = 0; ch < 2; ch++) begin
            frame(mk(3 + 3 * ch, 300 + ch * 111), 16, "R3 load-only");
            readback(ch, "R3 input holds new code");
        end
        frame(mk(1, 17), 16, "R2 update after load-only");

        // R5 every no-op command, two payloads
        foreach (m_in[i]) ;
        for (int c = 0; c < 16; c++) begin
            if (c == 0 || (c >= 7 && c <= 12) || c >= 14) begin
                frame({4'(c), 12'hFFF}, 16, "R5 no-op ones");
                frame({4'(c), 12'h555}, 16, "R5 no-op pattern");
            end
        end
        readback(0, "R5 ch0 after no-ops");
        readback(1, "R5 ch1 after no-ops");

        // R1 wrong clock counts discard the word
        frame(mk(1, 999), 15, "R1 short frame");
        frame(mk(4, 999), 17, "R1 long frame");
        readback(0, "R1 ch0 untouched");
        readback(1, "R1 ch1 untouched");

        // R6/R7 rising-edge sampling
        frame(ctrl_w(2'b00, 0, 0, 1), 16, "R6 ctrl rise");
        frame(mk(1, 612), 16, "R7 rising load");
        frame(mk(4, 77), 16, "R7 rising load ch1");
        readback(0, "R7 rising readback");
        frame(ctrl_w(2'b00, 0, 0, 0), 16, "R7 back to falling");
        frame(mk(4, 401), 16, "R7 falling load");

        // R8 SDO drive modes
        frame(ctrl_w(2'b01, 0, 0, 0), 16, "R8 open-drain");
        readback(1, "R8 open-drain readback");
        frame(ctrl_w(2'b10, 0, 0, 0), 16, "R8 alt push");
        readback(0, "R8 alt push readback");
        frame(ctrl_w(2'b11, 0, 0, 0), 16, "R8 off");
        readback(1, "R8 off readback");
        frame(mk(1, 5), 16, "R8 off still loads");
        frame(ctrl_w(2'b00, 0, 0, 0), 16, "R8 push again");

        // R9 chaining pass-through
        frame(ctrl_w(2'b00, 1, 0, 0), 16, "R9 chain on");
        frame(16'h0ABC, 16, "R9 chain word a");
        frame(16'hE123, 16, "R9 chain word b");
        frame(16'h7F0F, 16, "R9 chain word c");
        frame(ctrl_w(2'b00, 0, 0, 0), 16, "R9 chain off");
        frame(16'hFFFF, 16, "R9 zeros after off");

        // R10 clear to zero, then to midscale
        @(negedge clk); clr_n = 1'b0; m_clr = 1;
        for (int c = 0; c < 2; c++) begin m_in[c] = clr_val(); m_dac[c] = clr_val(); end
        repeat (10) @(negedge clk);
        chk("R10 clear zero dac0", int'(dac0_code), 0);
        chk("R10 clear zero dac1", int'(dac1_code), 0);
        clr_n = 1'b1; m_clr = 0;
        repeat (6) @(negedge clk);
        readback(1, "R10 readback zero");
        frame(ctrl_w(2'b00, 0, 1, 0), 16, "R10 ctrl midscale");
        frame(mk(1, 100), 16, "R10 load before clear");
        @(negedge clk); clr_n = 1'b0; m_clr = 1;
        for (int c = 0; c < 2; c++) begin m_in[c] = clr_val(); m_dac[c] = clr_val(); end
        repeat (10) @(negedge clk);
        chk("R10 clear mid dac0", int'(dac0_code), MID);
        chk("R10 clear mid dac1", int'(dac1_code), MID);
        frame(mk(4, 33), 16, "R10 load blocked during clear");
        clr_n = 1'b1; m_clr = 0;
        repeat (6) @(negedge clk);
        readback(0, "R10 readback midscale");

        // R11 reset mid-run drops staged read-back
        frame(mk(1, 444), 16, "R11 preload");
        frame(mk(2, 0), 16, "R11 stage read");
        @(negedge clk); rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        model_reset();
        repeat (4) @(negedge clk);
        chk("R11 reset dac0 after run", int'(dac0_code), 0);
        frame(16'h0000, 16, "R11 no stale read-back");

        summary();
        $finish;
    end

endmodule